// File: doc/BRIEF.md
# Greedy Pipeline Initiation Controller

This block decides, on every clock, whether a new task may enter a non-linear pipeline whose stages are reused at fixed latencies. The forbidden latencies are given as a parameterised collision pattern. Bit k-1 of that pattern set to 1 means that two tasks started k cycles apart would collide in some stage.

A shift register holds the collision state of all tasks still in flight. Its bit 0 tells whether the current cycle is free. Every cycle the register moves one place toward bit 0 and fills with zero at the top. On each start, the collision pattern is ORed into the shifted value. A task is started greedily: `initiate` is raised in the first cycle where data is waiting and the current bit is clear. No start is deferred to reach a better long-run schedule. The pattern sets both the register length and the number of OR terms.

The reset input is asynchronous and active low. Its release is taken through a two-stage synchroniser. No task starts until that release has reached the logic.

Top module: `greedy_init_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after `rst_n` goes high, `initiate` is 0.
- R2: `initiate` is never 1 while `dai` is 0.
- R3: After reset is released, the first cycle with `dai` high raises `initiate` in that same cycle.
- R4: Two starts never lie k cycles apart (1 <= k <= VEC_W) when bit k-1 of the parameter `ICV` is 1. Bit 0 is the LSB and stands for latency 1.
- R5: When `dai` is high and no earlier start lies at a forbidden latency, `initiate` is 1 in that cycle, so no start is delayed without cause.
- R6: A start more than VEC_W cycles after every earlier start is always permitted.
- R7: Asserting reset in mid-operation discards all collision history. After the next release, the first `dai` starts at once.
- R8: When several earlier starts are still within VEC_W cycles, a new start is refused if any one of them lies at a forbidden latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dai | input | 1 | A task's data is ready to enter the pipeline |
| initiate | output | 1 | Start the waiting task in this cycle (combinational from `dai`) |

## Verification
The bench aims at four corner cases.
- Back-to-back demand with `dai` held high. A register shifted the wrong way, or ORed with a pattern shifted one place, would let a start through at a forbidden latency or would block a legal one.
- Demand that repeats at exactly a forbidden latency. Here only the merged history from several older starts decides the outcome, so a design that kept just the latest start would wrongly admit a task.
- Gaps longer than the vector. A design that left stale bits behind would wrongly refuse a task.
- Mid-run reset, and the two-cycle release window. A design without the synchroniser gate would start a task too early, and one that kept its history would wrongly refuse the first task after release.

// File: rtl/gip_pkg.sv
package gip_pkg;
  // number of flops in the reset release synchroniser
  localparam int unsigned GIP_SYNC_STAGES = 2;

  // true when any bit of a collision pattern is set at a latency inside width w
  function automatic logic gip_any_set(input logic [63:0] pat, input int unsigned w);
    logic r;
    r = 1'b0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w) r = r | pat[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/gip_rst_sync.sv
module gip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[LAST];
endmodule

// File: rtl/gip_coll_shreg.sv
module gip_coll_shreg #(
  parameter int unsigned          VEC_W = 7,
  parameter logic [VEC_W-1:0]     ICV   = 7'b1011010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             merge,
  output logic [VEC_W-1:0] vec
);
  localparam int unsigned TOP = VEC_W - 1;

  logic [VEC_W-1:0] vec_d;

  // next state: move one place toward bit 0, zero fill, OR in pattern on a start
  generate
    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
      if (i == TOP) begin : g_top
        if (ICV[i]) begin : g_or
          always_comb vec_d[i] = merge;
        end else begin : g_zero
          always_comb vec_d[i] = 1'b0;
        end
      end else begin : g_mid
        if (ICV[i]) begin : g_or
          always_comb vec_d[i] = vec[i+1] | merge;
        end else begin : g_pass
          always_comb vec_d[i] = vec[i+1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vec <= '0;
    else if (clr) vec <= '0;
    else if (en)  vec <= vec_d;
  end
endmodule

// File: rtl/gip_grant.sv
module gip_grant (
  input  logic run,
  input  logic dai,
  input  logic slot_busy,
  output logic initiate
);
  always_comb initiate = run & dai & ~slot_busy;
endmodule

// File: rtl/greedy_init_ctrl.sv
module greedy_init_ctrl #(
  parameter int unsigned      VEC_W = 7,
  parameter logic [VEC_W-1:0] ICV   = 7'b1011010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dai,
  output logic initiate
);
  import gip_pkg::*;

  logic             run;
  logic [VEC_W-1:0] vec;

  gip_rst_sync #(.STAGES(GIP_SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  gip_coll_shreg #(.VEC_W(VEC_W), .ICV(ICV)) u_shreg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~run),
    .en    (run),
    .merge (initiate),
    .vec   (vec)
  );

  gip_grant u_grant (
    .run       (run),
    .dai       (dai),
    .slot_busy (vec[0]),
    .initiate  (initiate)
  );
endmodule

// File: rtl/gip_chk.sv
module gip_chk #(
  parameter int unsigned      VEC_W = 7,
  parameter logic [VEC_W-1:0] ICV   = 7'b1011010
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             dai,
  input logic             initiate,
  input logic [VEC_W-1:0] vec
);
  // hist[k-1] : a start happened k cycles ago
  logic [VEC_W-1:0] hist;
  logic [VEC_W:0]   hist_ext;
  logic             conflict;

  always_comb hist_ext = {hist, initiate};
  always_comb conflict = |(hist & ICV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist <= '0;
    else if (!run) hist <= '0;
    else           hist <= hist_ext[VEC_W-1:0];
  end

  // R1
  held_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !initiate);

  // R2
  no_start_without_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    initiate |-> dai);

  // R4
  no_forbidden_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    initiate |-> !conflict);

  // R5
  greedy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dai && !conflict) |-> initiate);

  // R7
  history_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (vec == '0));
endmodule

bind greedy_init_ctrl gip_chk #(.VEC_W(VEC_W), .ICV(ICV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .dai      (dai),
  .initiate (initiate),
  .vec      (vec)
);

// File: tb/tb_greedy_init_ctrl.sv
`timescale 1ns/1ps
module tb_greedy_init_ctrl;
  localparam int unsigned      VW  = 7;
  localparam logic [VW-1:0]    ICV = 7'b1011010;

  logic clk;
  logic rst_n;
  logic dai;
  logic initiate;

  int          checks;
  int          errors;
  bit          done;
  logic [VW-1:0] hist;
  int          since_rel;
  bit          seen;
  int          releases;
  int unsigned seed_v;

  greedy_init_ctrl #(.VEC_W(VW), .ICV(ICV)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .dai      (dai),
    .initiate (initiate)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic model(input logic d, input bit r, input logic [VW-1:0] h);
    return d && r && ((h & ICV) == '0);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t initiate=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic r);
    bit    run_m;
    logic  exp;
    string tag;
    @(negedge clk);
    if (r && !rst_n) releases++;
    rst_n = r;
    dai   = d;
    #5;
    run_m = rst_n && (since_rel >= 2);
    exp   = model(d, run_m, hist);
    if (!run_m)                 tag = "R1";
    else if (!d)                tag = "R2";
    else if (!seen)             tag = (releases > 1) ? "R7" : "R3";
    else if (!exp)              tag = "R4";
    else if (hist == '0)        tag = "R6";
    else if ($countones(hist) > 1) tag = "R8";
    else                        tag = "R5";
    chk(tag, initiate, exp);
    @(posedge clk);
    if (rst_n) since_rel++; else since_rel = 0;
    if (run_m) begin
      hist = {hist[VW-2:0], exp};
      if (exp) seen = 1'b1;
    end else begin
      hist = '0;
      seen = 1'b0;
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    hist = '0; since_rel = 0; seen = 0; releases = 0;
    rst_n = 1'b0; dai = 1'b0;
    seed_v = $urandom(32'd4242);
    // reset state, with data waiting (R1)
    repeat (3) step(1'b1, 1'b0);
    // release window: two cycles still held (R1)
    repeat (2) step(1'b1, 1'b1);
    // continuous demand: greedy pattern (R3 R4 R5 R8)
    repeat (25) step(1'b1, 1'b1);
    // idle beyond the vector, then demand (R2 R6)
    repeat (VW + 3) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    // demand at fixed spacings, including forbidden ones (R4)
    for (int sp = 1; sp <= VW + 1; sp++) begin
      repeat (VW + 2) step(1'b0, 1'b1);
      for (int n = 0; n < 4; n++) begin
        step(1'b1, 1'b1);
        repeat (sp - 1) step(1'b0, 1'b1);
      end
    end
    // mid-run reset with demand held (R7)
    repeat (3) step(1'b1, 1'b1);
    repeat (2) step(1'b1, 1'b0);
    repeat (10) step(1'b1, 1'b1);
    // constrained random demand with varying density
    for (int blk = 0; blk < 12; blk++) begin
      int unsigned dens;
      dens = 20 + ($urandom % 80);
      for (int c = 0; c < 120; c++) begin
        step(($urandom % 100) < dens, 1'b1);
      end
      if (blk == 6) begin
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule